// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

This block runs one trigger cycle of a data acquisition system from the moment a qualified level-1 trigger is taken up to the point where the event is either stored for readout or thrown away. It takes the trigger class and the readout code that an input latch outside the block has captured. It starts the higher trigger levels that the class calls for, collects their pass or fail answers and drives the gating accepts for the front end. It also drives a clear toward the front end, a write strobe toward the branch buffers, and two tag bits that travel with each stored code.

When a class skips a decision level, the block makes the missing accepts itself from programmable delays counted from level-1 accept. A hold timer, also started at level-1 accept, marks the point after which the front end can no longer discard data. A fail that arrives after that point is stored with a late tag and no clear is issued. An event counter forces a synchronization event every programmed number of stored events. Software can also request a synchronization event, which is written with a zero code. Each synchronization event holds the sequencer until the readers acknowledge it.

Top module: `trig_main_seq`

## Requirements
- R1: `ready` is high only when the sequencer is idle, `enable` is high, `fe_busy` is low and no user sync is pending. A `trig_valid` seen while `ready` is high raises `l1_acc` on the next cycle, and a `trig_valid` while `ready` is low has no effect.
- R2: `trig_class` encodes 1 = no higher level, 2 = level 2 only, 3 = levels 2 and 3, and 0 is handled as 1. `l2_start` rises in the same cycle as `l1_acc` for classes 2 and 3 and stays low for class 1.
- R3: Class 3: a level-2 pass sampled while `l2_start` is high gives `l2_acc` and `l3_start` on the next cycle and drops `l2_start`. A level-3 pass sampled while `l3_start` is high then gives `l3_acc` on the next cycle.
- R4: Class 1: neither start output rises and the pass/fail inputs are ignored. `l2_acc` rises `l2_delay`+1 cycles after `l1_acc`, and `l3_acc` rises `l3_delay`+1 cycles after `l1_acc`.
- R5: Class 2: `l2_acc` follows a level-2 pass one cycle later. `l3_acc` rises one cycle after both `l2_acc` is high and `l3_delay` cycles have passed since `l1_acc`.
- R6: A fail on an awaited level, sampled before the hold timer has expired, raises `clear` on the next cycle and drops all accepts and starts. `clear` stays high while `fe_busy` is high, the block is ready again one cycle after `fe_busy` falls, and nothing is written.
- R7: Once both `l2_acc` and `l3_acc` are high, the block waits for `fe_busy` low and then gives a one-cycle `buf_wr` carrying the latched code on `wr_code`. Two cycles later it drops the accepts and rearms.
- R8: If any bit of `buf_full` is high two cycles after `buf_wr`, the accepts stay high and `ready` stays low until every bit of `buf_full` is low.
- R9: With `late_en` high, a fail sampled `hold_time` or more cycles after `l1_acc` raises no clear. The event is instead written with `wr_late` = 1.
- R10: With `late_en` low, every fail on an awaited level gives a clear, however late it comes.
- R11: With `sync_en` high, the `sync_period`-th stored event since the last sync is written with `wr_sync` = 1. The block then holds its accepts and does not rearm until `sync_ack`, and the event count restarts from zero. With `sync_en` low, `wr_sync` stays 0.
- R12: A `sync_req` pulse with `sync_en` high blocks new triggers. Once the block is idle and `fe_busy` is low, it writes `wr_code` = 0 with `wr_sync` = 1 without raising `l1_acc`, then waits for `sync_ack`. A `sync_req` with `sync_en` low is ignored.
- R13: Dropping `enable` during a cycle lets that cycle finish, including its buffer write, but the block does not rearm until `enable` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | User enable for taking new triggers |
| trig_valid | input | 1 | Qualified level-1 trigger from the input latch |
| trig_class | input | 2 | Latched trigger class |
| trig_code | input | CODE_W | Readout code for the latched pattern |
| l2_pass | input | 1 | Level-2 pass answer |
| l2_fail | input | 1 | Level-2 fail answer |
| l3_pass | input | 1 | Level-3 pass answer |
| l3_fail | input | 1 | Level-3 fail answer |
| fe_busy | input | 1 | Front end busy |
| buf_full | input | N_BRANCH | Per-branch buffer at maximum depth |
| sync_ack | input | 1 | All readers have acknowledged the sync event |
| sync_req | input | 1 | User request for a sync event |
| late_en | input | 1 | Enables the late-fail hold timer |
| sync_en | input | 1 | Enables synchronization events |
| l2_delay | input | DLY_W | Synthesized level-2 accept delay |
| l3_delay | input | DLY_W | Synthesized level-3 accept delay |
| hold_time | input | HOLD_W | Cycles after level-1 accept until a fail counts as late |
| sync_period | input | SCNT_W | Stored events per periodic sync (0 = never) |
| ready | output | 1 | Sequencer can take a trigger |
| l1_acc | output | 1 | Level-1 accept |
| l2_acc | output | 1 | Level-2 accept |
| l3_acc | output | 1 | Level-3 accept |
| l2_start | output | 1 | Start of the level-2 trigger logic |
| l3_start | output | 1 | Start of the level-3 trigger logic |
| clear | output | 1 | Clear toward the front end |
| buf_wr | output | 1 | One-cycle write strobe to all branch buffers |
| wr_code | output | CODE_W | Code written with `buf_wr` |
| wr_late | output | 1 | Late-fail tag written with `buf_wr` |
| wr_sync | output | 1 | Sync tag written with `buf_wr` |

## Verification
The main cycle is driven from a table covering each class with pass-pass, early fail at level 2, and pass followed by fail at level 3. It separates the start and accept timing of the three classes, including class 1 with fail pulses that must be ignored. Fails placed one cycle before and exactly on the hold-timer expiry separate a clear from a late-tagged write, and the same late fail with the timer disabled must give a clear. Directed runs then hold `fe_busy` across the store and across a clear, keep one buffer full, count to a periodic sync, and issue a user sync with a trigger pending. They also drop `enable` mid-cycle, so that writing, holding and rearming are each observed apart.

// File: rtl/trigseq_pkg.sv
package trigseq_pkg;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ONE   = 2'd1,
        CLS_TWO   = 2'd2,
        CLS_THREE = 2'd3
    } tclass_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_RUN   = 3'd1,
        S_STORE = 3'd2,
        S_POST  = 3'd3,
        S_CHK   = 3'd4,
        S_SYNC  = 3'd5,
        S_CLR   = 3'd6
    } seq_state_e;

endpackage

// File: rtl/tseq_timer.sv
// Programmable one-shot down counter: done rises load cycles after start and
// stays high until the next start.
module tseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] load,
    output logic         done
);
    typedef struct packed {
        logic         armed;
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.armed = 1'b1;
            t_d.cnt   = load;
        end else if (t_q.armed && t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign done = t_q.armed && (t_q.cnt == '0);

    // R4: a restart with a nonzero load always withdraws expiry
    p_reload_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && load != '0) |=> !done);

endmodule

// File: rtl/tseq_evcount.sv
// Counts stored events; hit flags that the next stored event closes the period.
module tseq_evcount #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         inc,
    input  logic         clr,
    input  logic [W-1:0] target,
    output logic         hit
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (en && inc && cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = en && (target != '0) &&
                 (({1'b0, cnt_q} + 1'b1) == {1'b0, target});

    // R11: an acknowledged sync restarts the period count
    p_count_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/trig_main_seq.sv
module trig_main_seq
    import trigseq_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int N_BRANCH = 4,
    parameter int DLY_W    = 8,
    parameter int HOLD_W   = 8,
    parameter int SCNT_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                trig_valid,
    input  logic [1:0]          trig_class,
    input  logic [CODE_W-1:0]   trig_code,
    input  logic                l2_pass,
    input  logic                l2_fail,
    input  logic                l3_pass,
    input  logic                l3_fail,
    input  logic                fe_busy,
    input  logic [N_BRANCH-1:0] buf_full,
    input  logic                sync_ack,
    input  logic                sync_req,
    input  logic                late_en,
    input  logic                sync_en,
    input  logic [DLY_W-1:0]    l2_delay,
    input  logic [DLY_W-1:0]    l3_delay,
    input  logic [HOLD_W-1:0]   hold_time,
    input  logic [SCNT_W-1:0]   sync_period,
    output logic                ready,
    output logic                l1_acc,
    output logic                l2_acc,
    output logic                l3_acc,
    output logic                l2_start,
    output logic                l3_start,
    output logic                clear,
    output logic                buf_wr,
    output logic [CODE_W-1:0]   wr_code,
    output logic                wr_late,
    output logic                wr_sync
);

    typedef struct packed {
        seq_state_e          st;
        tclass_e             cls;
        logic [CODE_W-1:0]   code;
        logic                l1;
        logic                l2;
        logic                l3;
        logic                s2;
        logic                s3;
        logic                clr;
        logic                wr;
        logic                late;
        logic                sync;
        logic                pend;
    } seq_t;

    seq_t r_d, r_q;

    logic    take_trig, store_fire, sync_done;
    logic    t2_done, t3_done, hold_done;
    logic    ev_hit;
    logic    f2, p2, f3, p3, late_now, any_fail;
    tclass_e cls_in;

    // ---- timers started by level-1 accept ----
    tseq_timer #(.W(DLY_W)) u_dly2 (
        .clk(clk), .rst_n(rst_n), .start(take_trig), .load(l2_delay), .done(t2_done));

    tseq_timer #(.W(DLY_W)) u_dly3 (
        .clk(clk), .rst_n(rst_n), .start(take_trig), .load(l3_delay), .done(t3_done));

    tseq_timer #(.W(HOLD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .start(take_trig), .load(hold_time), .done(hold_done));

    tseq_evcount #(.W(SCNT_W)) u_evcnt (
        .clk(clk), .rst_n(rst_n), .en(sync_en), .inc(store_fire), .clr(sync_done),
        .target(sync_period), .hit(ev_hit));

    assign ready = (r_q.st == S_IDLE) && enable && !fe_busy && !r_q.pend;

    assign cls_in   = (tclass_e'(trig_class) == CLS_NONE) ? CLS_ONE : tclass_e'(trig_class);
    assign f2       = r_q.s2 && l2_fail;
    assign p2       = r_q.s2 && l2_pass && !l2_fail;
    assign f3       = r_q.s3 && l3_fail;
    assign p3       = r_q.s3 && l3_pass && !l3_fail;
    assign any_fail = f2 || f3;
    assign late_now = late_en && hold_done;

    always_comb begin
        r_d        = r_q;
        r_d.wr     = 1'b0;
        take_trig  = 1'b0;
        store_fire = 1'b0;
        sync_done  = 1'b0;

        if (sync_en && sync_req)
            r_d.pend = 1'b1;

        case (r_q.st)
            S_IDLE: begin
                if (r_q.pend && !fe_busy) begin
                    // user sync: zero code tagged with sync, no level-1 accept
                    r_d.wr   = 1'b1;
                    r_d.code = '0;
                    r_d.sync = 1'b1;
                    r_d.late = 1'b0;
                    r_d.pend = 1'b0;
                    r_d.st   = S_POST;
                end else if (ready && trig_valid) begin
                    take_trig = 1'b1;
                    r_d.cls   = cls_in;
                    r_d.code  = trig_code;
                    r_d.l1    = 1'b1;
                    r_d.s2    = (cls_in != CLS_ONE);
                    r_d.st    = S_RUN;
                end
            end

            S_RUN: begin
                if (any_fail) begin
                    r_d.s2 = 1'b0;
                    r_d.s3 = 1'b0;
                    if (late_now) begin
                        r_d.late = 1'b1;
                        r_d.st   = S_STORE;
                    end else begin
                        r_d.clr = 1'b1;
                        r_d.l1  = 1'b0;
                        r_d.l2  = 1'b0;
                        r_d.l3  = 1'b0;
                        r_d.st  = S_CLR;
                    end
                end else begin
                    if (p2) begin
                        r_d.l2 = 1'b1;
                        r_d.s2 = 1'b0;
                        r_d.s3 = (r_q.cls == CLS_THREE);
                    end
                    if (p3) begin
                        r_d.l3 = 1'b1;
                        r_d.s3 = 1'b0;
                    end
                    if (r_q.cls == CLS_ONE) begin
                        if (t2_done) r_d.l2 = 1'b1;
                        if (t3_done) r_d.l3 = 1'b1;
                    end
                    if (r_q.cls == CLS_TWO && r_q.l2 && t3_done)
                        r_d.l3 = 1'b1;
                    if (r_q.l2 && r_q.l3)
                        r_d.st = S_STORE;
                end
            end

            S_STORE: begin
                if (!fe_busy) begin
                    r_d.wr     = 1'b1;
                    r_d.sync   = ev_hit;
                    store_fire = 1'b1;
                    r_d.st     = S_POST;
                end
            end

            S_POST: r_d.st = S_CHK;

            S_CHK: begin
                if (r_q.sync) begin
                    r_d.st = S_SYNC;
                end else if (buf_full == '0) begin
                    r_d.l1   = 1'b0;
                    r_d.l2   = 1'b0;
                    r_d.l3   = 1'b0;
                    r_d.late = 1'b0;
                    r_d.st   = S_IDLE;
                end
            end

            S_SYNC: begin
                if (sync_ack) begin
                    sync_done = 1'b1;
                    r_d.l1    = 1'b0;
                    r_d.l2    = 1'b0;
                    r_d.l3    = 1'b0;
                    r_d.late  = 1'b0;
                    r_d.sync  = 1'b0;
                    r_d.st    = S_IDLE;
                end
            end

            S_CLR: begin
                if (!fe_busy) begin
                    r_d.clr = 1'b0;
                    r_d.st  = S_IDLE;
                end
            end

            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign l1_acc   = r_q.l1;
    assign l2_acc   = r_q.l2;
    assign l3_acc   = r_q.l3;
    assign l2_start = r_q.s2;
    assign l3_start = r_q.s3;
    assign clear    = r_q.clr;
    assign buf_wr   = r_q.wr;
    assign wr_code  = r_q.code;
    assign wr_late  = r_q.late;
    assign wr_sync  = r_q.sync;

    // ---- assertions ----
    p_accept_needs_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l1_acc) |-> $past(ready && trig_valid));

    p_start_by_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l1_acc) |-> (l2_start == (r_q.cls != CLS_ONE)));

    p_l3start_after_l2acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        l3_start |-> (l2_acc && l1_acc));

    p_class1_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_acc && r_q.cls == CLS_ONE) |-> (!l2_start && !l3_start));

    p_clear_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> (!buf_wr && !l1_acc && !l2_acc && !l3_acc));

    p_write_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> !buf_wr);

    p_write_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_wr) |-> $past(!fe_busy));

    p_late_no_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_late |-> !clear);

    p_user_sync_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && !l1_acc) |-> (wr_sync && wr_code == '0));

endmodule

// File: tb/test_trig_main_seq.sv
`timescale 1ns/1ps
module test_trig_main_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1, trig_valid = 1'b0;
    logic [1:0] trig_class = 2'd1;
    logic [3:0] trig_code = '0;
    logic       l2_pass = 0, l2_fail = 0, l3_pass = 0, l3_fail = 0;
    logic       fe_busy = 0, sync_ack = 0, sync_req = 0, late_en = 1, sync_en = 0;
    logic [3:0] buf_full = '0;
    logic [7:0] l2_delay = '0, l3_delay = '0, hold_time = 8'd50, sync_period = '0;
    logic       ready, l1_acc, l2_acc, l3_acc, l2_start, l3_start, clear, buf_wr;
    logic [3:0] wr_code;
    logic       wr_late, wr_sync;

    int n_chk = 0, n_err = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    trig_main_seq i_trig_main_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .trig_valid(trig_valid),
        .trig_class(trig_class), .trig_code(trig_code),
        .l2_pass(l2_pass), .l2_fail(l2_fail), .l3_pass(l3_pass), .l3_fail(l3_fail),
        .fe_busy(fe_busy), .buf_full(buf_full), .sync_ack(sync_ack), .sync_req(sync_req),
        .late_en(late_en), .sync_en(sync_en), .l2_delay(l2_delay), .l3_delay(l3_delay),
        .hold_time(hold_time), .sync_period(sync_period),
        .ready(ready), .l1_acc(l1_acc), .l2_acc(l2_acc), .l3_acc(l3_acc),
        .l2_start(l2_start), .l3_start(l3_start), .clear(clear), .buf_wr(buf_wr),
        .wr_code(wr_code), .wr_late(wr_late), .wr_sync(wr_sync));

    typedef struct packed {
        int cls; int code; int d2; int d3; int hold;
        int r2; int t2; int r3; int t3; int late;
        int ex_clr; int ex_late; int ex2; int ex3;
    } vec_t;

    // response code: 0 none, 1 pass, 2 fail; ex2/ex3: cycle of accept rise, -1 never
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{3,  5, 0, 0, 50, 1, 2, 1, 4, 1, 0, 0,  3,  5},
        '{3,  6, 0, 0, 50, 2, 2, 0, 0, 1, 1, 0, -1, -1},
        '{3,  7, 0, 0, 50, 1, 1, 2, 3, 1, 1, 0,  2, -1},
        '{1,  9, 3, 6, 50, 2, 1, 0, 0, 1, 0, 0,  4,  7},
        '{2, 10, 0, 2, 50, 1, 5, 0, 0, 1, 0, 0,  6,  7},
        '{2, 11, 0, 9, 50, 1, 1, 0, 0, 1, 0, 0,  2, 10},
        '{3, 12, 0, 0,  4, 1, 1, 2, 6, 1, 0, 1,  2, -1},
        '{3, 13, 0, 0,  4, 1, 1, 2, 6, 0, 1, 0,  2, -1},
        '{3, 14, 0, 0,  4, 2, 3, 0, 0, 1, 1, 0, -1, -1},
        '{3, 15, 0, 0,  4, 2, 4, 0, 0, 1, 0, 1, -1, -1},
        '{2,  3, 0, 0,  4, 2, 4, 0, 0, 1, 0, 1, -1, -1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic fire(input int cls, input int code);
        int w = 0;
        while (!ready && w < 100) begin tick(); w++; end
        trig_valid = 1'b1;
        trig_class = cls[1:0];
        trig_code  = code[3:0];
        tick();
        trig_valid = 1'b0;
    endtask

    task automatic wait_wr(output bit got, output int code, output int late, output int sy);
        got = 0; code = -1; late = -1; sy = -1;
        for (int i = 0; i < 60; i++) begin
            if (buf_wr) begin got = 1; code = wr_code; late = wr_late; sy = wr_sync; break; end
            tick();
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int k = 0, k2 = -1, k3 = -1, wc = -1, wl = -1, ws = -1;
        bit s2k0 = 0, seen_clr = 0, seen_wr = 0, clr_bad = 0;
        l2_delay  = v.d2[7:0];
        l3_delay  = v.d3[7:0];
        hold_time = v.hold[7:0];
        late_en   = v.late[0];
        fire(v.cls, v.code);
        while (k < 80) begin
            if (k == 0) s2k0 = l2_start;
            if (l2_acc && k2 < 0) k2 = k;
            if (l3_acc && k3 < 0) k3 = k;
            if (clear) begin
                seen_clr = 1;
                if (l1_acc || l2_acc || l3_acc) clr_bad = 1;
            end
            if (buf_wr) begin seen_wr = 1; wc = wr_code; wl = wr_late; ws = wr_sync; end
            if (k > 0 && ready) break;
            l2_pass = (v.r2 == 1 && k == v.t2);
            l2_fail = (v.r2 == 2 && k == v.t2);
            l3_pass = (v.r3 == 1 && k == v.t3);
            l3_fail = (v.r3 == 2 && k == v.t3);
            tick();
            k++;
        end
        l2_pass = 0; l2_fail = 0; l3_pass = 0; l3_fail = 0;
        $display("vector %0d class %0d", idx, v.cls);
        check(s2k0 == (v.cls != 1), "R2 l2_start with l1_acc", s2k0, v.cls != 1);
        check(seen_clr == v.ex_clr[0], "R6/R9/R10 clear issued", seen_clr, v.ex_clr);
        check(seen_wr == !v.ex_clr[0], "R7 buffer write", seen_wr, !v.ex_clr[0]);
        check(!clr_bad, "R6 accepts low under clear", clr_bad, 0);
        if (seen_wr) begin
            check(wc == v.code, "R7 written code", wc, v.code);
            check(wl == v.ex_late, "R9 late tag", wl, v.ex_late);
            check(ws == 0, "R11 no sync tag when disabled", ws, 0);
        end
        if (v.cls == 3) check(k2 == v.ex2, "R3 l2_acc cycle", k2, v.ex2);
        if (v.cls == 1) check(k2 == v.ex2, "R4 l2_acc cycle", k2, v.ex2);
        if (v.cls == 2) check(k2 == v.ex2, "R5 l2_acc cycle", k2, v.ex2);
        if (v.cls == 1)      check(k3 == v.ex3, "R4 l3_acc cycle", k3, v.ex3);
        else if (v.cls == 2) check(k3 == v.ex3, "R5 l3_acc cycle", k3, v.ex3);
        else                 check(k3 == v.ex3, "R3 l3_acc cycle", k3, v.ex3);
        check(ready == 1, "R1 rearmed after cycle", ready, 1);
    endtask

    initial begin
        #(200000 * 4);
        if (!done_flag) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        bit got;
        int c, lt, sy;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check(ready == 1, "R1 ready after reset", ready, 1);
        check({l1_acc, l2_acc, l3_acc, l2_start, l3_start, clear, buf_wr} == 0,
              "R1 outputs idle after reset",
              int'({l1_acc, l2_acc, l3_acc, l2_start, l3_start, clear, buf_wr}), 0);

        // R1 trigger ignored while not ready
        fe_busy = 1; trig_valid = 1; trig_class = 2'd3;
        tick(); tick();
        trig_valid = 0;
        check(l1_acc == 0, "R1 trigger ignored when busy", l1_acc, 0);
        fe_busy = 0;
        tick();

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
        late_en = 1; hold_time = 8'd50; l2_delay = 0; l3_delay = 0;

        // R7 store waits for front end busy to fall
        fire(1, 4);
        fe_busy = 1;
        got = 0;
        for (int i = 0; i < 6; i++) begin tick(); if (buf_wr) got = 1; end
        check(got == 0, "R7 no write while busy", got, 0);
        check(l1_acc == 1, "R7 accepts held while busy", l1_acc, 1);
        fe_busy = 0;
        wait_wr(got, c, lt, sy);
        check(got == 1 && c == 4, "R7 write after busy drops", c, 4);

        // R6 clear held while busy
        fire(3, 2);
        l2_fail = 1; fe_busy = 1;
        tick();
        l2_fail = 0;
        repeat (5) tick();
        check(clear == 1, "R6 clear held while busy", clear, 1);
        check(ready == 0, "R6 locked while busy", ready, 0);
        fe_busy = 0;
        tick();
        check(clear == 0, "R6 clear released", clear, 0);
        check(ready == 1, "R6 rearmed after busy", ready, 1);

        // R8 full buffer holds the rearm
        buf_full = 4'b0100;
        fire(1, 1);
        wait_wr(got, c, lt, sy);
        repeat (6) tick();
        check(l1_acc == 1, "R8 accepts held while full", l1_acc, 1);
        check(ready == 0, "R8 no rearm while full", ready, 0);
        buf_full = '0;
        tick();
        check(ready == 1 && l1_acc == 0, "R8 rearm once space", ready, 1);

        // R13 enable dropped mid-cycle
        fire(3, 8);
        enable = 0; l2_pass = 1;
        tick();
        l2_pass = 0; l3_pass = 1;
        tick();
        l3_pass = 0;
        wait_wr(got, c, lt, sy);
        check(got == 1 && c == 8, "R13 cycle completes after disable", c, 8);
        repeat (6) tick();
        check(ready == 0, "R13 no rearm while disabled", ready, 0);
        check(l1_acc == 0, "R13 accepts dropped", l1_acc, 0);
        enable = 1;
        tick();
        check(ready == 1, "R13 rearm on enable", ready, 1);

        // R11 periodic sync every third stored event
        sync_en = 1; sync_period = 8'd3;
        for (int e = 1; e <= 3; e++) begin
            fire(1, e);
            wait_wr(got, c, lt, sy);
            check(sy == (e == 3), "R11 sync tag on period event", sy, e == 3);
        end
        repeat (6) tick();
        check(l1_acc == 1 && ready == 0, "R11 hold until sync ack", l1_acc, 1);
        sync_ack = 1;
        tick();
        sync_ack = 0;
        tick();
        check(ready == 1 && l1_acc == 0, "R11 rearm after ack", ready, 1);
        fire(1, 6);
        wait_wr(got, c, lt, sy);
        check(sy == 0, "R11 count restarted", sy, 0);

        // R12 user sync request
        tick(); tick(); tick();
        fe_busy = 1; sync_req = 1;
        tick();
        sync_req = 0;
        tick();
        fe_busy = 0; trig_valid = 1; trig_class = 2'd3; trig_code = 4'd9;
        tick();
        trig_valid = 0;
        check(buf_wr == 1 && wr_sync == 1, "R12 sync event written", buf_wr, 1);
        check(wr_code == 0, "R12 zero code", wr_code, 0);
        check(l1_acc == 0, "R12 trigger blocked", l1_acc, 0);
        repeat (5) tick();
        check(ready == 0, "R12 wait for ack", ready, 0);
        sync_ack = 1;
        tick();
        sync_ack = 0;
        tick();
        check(ready == 1, "R12 rearm after ack", ready, 1);
        sync_en = 0; sync_req = 1;
        tick();
        sync_req = 0;
        tick(); tick();
        check(ready == 1, "R12 request ignored when disabled", ready, 1);

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule